// File: doc/BRIEF.md
# Page Access Permission and Protection-Key Checker

This block takes the outcome of a finished page-table walk and decides what the access may do. Its inputs are the walk status, the combined user, writable and no-execute bits of the walked entries, the protection key of the final entry, and the access context. The context is the access kind, the privilege, the supervisor-no-user-data condition, the paging mode enables and the two key-rights registers. From these it produces the final read/write/execute set, a fault flag and a page-fault error code.

The block registers each request once. A request presented with `req_valid` in one cycle has its result on the outputs after the next rising clock edge, with `rsp_valid` high. When no request is presented, the result outputs keep their last value and `rsp_valid` drops.

The access kind is encoded as 0 for load, 1 for store and 2 for fetch. Code 3 is treated as a load. The walk status is encoded as 0 for a clean walk, 1 for an entry that was not present, and 2 or 3 for a reserved-bit violation. The error code uses these bits:

- bit 0: protection violation
- bit 1: write access
- bit 2: user-mode access
- bit 3: reserved-bit violation
- bit 4: instruction fetch
- bit 5: protection-key violation

Top module: `pg_perm_check`

## Requirements
- R1: After reset, `rsp_valid`, all three permission bits, `fault` and `err_code` are 0. A request taken with `req_valid` high produces its result one clock later with `rsp_valid` high. A cycle without a request gives `rsp_valid` low in the following cycle.
- R2: A walk status of 1 (not present) faults with base error bits 0. A walk status of 2 or 3 (reserved) faults with bit 3 set. In both cases the permission set is all zero.
- R3: A user-mode access to an entry whose combined user bit is clear faults with bit 0 set, and the permission set is all zero.
- R4: Read is granted except for a supervisor access, under the supervisor-no-user-data condition, to a user entry.
- R5: Write is granted only where read is granted, and then only if the writable bit is set, or if the access is supervisor-mode and write-protect is clear.
- R6: Execute is granted when the no-execute bit is clear and either the access is user-mode or it is not the case that supervisor-execute-prevention is on and the entry is a user entry.
- R7: User entries take key rights from `user_rights` when `key_user_en` is set. Supervisor entries take key rights from `sup_rights` when `key_sup_en` is set. Otherwise the rights are zero and no key limits apply.
- R8: For key k, rights bit 2k removes read and write. Rights bit 2k+1 removes write only when the access is user-mode or write-protect is set. Keys other than the entry's key have no effect.
- R9: A request the key rights deny faults with error bits 5 and 0 both set. This check takes precedence over the ordinary permission check. An instruction fetch never takes a key fault.
- R10: A faulting error code adds bit 2 for user-mode accesses and bit 1 for stores. It adds bit 4 for fetches only when no-execute enable or execute prevention is on.
- R11: `fault` is set exactly when the permission bit for the requested access is clear in the final set, which is the page set ANDed with the key set, or when R2 or R3 applies. Without a fault, `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| walk_stat | input | 2 | 0 clean, 1 not present, 2/3 reserved |
| priv_user | input | 1 | Access made in user mode |
| sup_no_udata | input | 1 | Supervisor access barred from user data |
| pte_user | input | 1 | Combined user bit |
| pte_rw | input | 1 | Combined writable bit |
| pte_nx | input | 1 | Combined no-execute bit |
| pte_key | input | KEY_W | Protection key of the final entry |
| md_wp | input | 1 | Write-protect enable |
| md_nxe | input | 1 | No-execute enable |
| md_smep | input | 1 | Supervisor execute prevention |
| key_user_en | input | 1 | Key rights enabled for user entries |
| key_sup_en | input | 1 | Key rights enabled for supervisor entries |
| user_rights | input | 2<<KEY_W | Key rights for user entries |
| sup_rights | input | 2<<KEY_W | Key rights for supervisor entries |
| rsp_valid | output | 1 | Result present |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| fault | output | 1 | Access faults |
| err_code | output | 6 | Page-fault error code |

## Verification
The bench builds the block with the default `KEY_W` of 4. That gives 16 keys and 32-bit rights registers, so the rights bits of low, middle and high keys can all be addressed. This includes cases where a neighbouring key carries a disable bit that must not affect the access. Each fault cause is exercised, together with the precedence of a key fault over an ordinary permission fault and the fetch exemption from key checks.

// File: rtl/pg_perm_check.sv
module pg_perm_check #(
  parameter int KEY_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [1:0]            acc_kind,
  input  logic [1:0]            walk_stat,
  input  logic                  priv_user,
  input  logic                  sup_no_udata,
  input  logic                  pte_user,
  input  logic                  pte_rw,
  input  logic                  pte_nx,
  input  logic [KEY_W-1:0]      pte_key,
  input  logic                  md_wp,
  input  logic                  md_nxe,
  input  logic                  md_smep,
  input  logic                  key_user_en,
  input  logic                  key_sup_en,
  input  logic [(2<<KEY_W)-1:0] user_rights,
  input  logic [(2<<KEY_W)-1:0] sup_rights,
  output logic                  rsp_valid,
  output logic                  perm_r,
  output logic                  perm_w,
  output logic                  perm_x,
  output logic                  fault,
  output logic [5:0]            err_code
);
  localparam int RIGHTS_W = 2 << KEY_W;
  localparam int EB_P = 0, EB_W = 1, EB_U = 2, EB_RSVD = 3, EB_ID = 4, EB_PK = 5;

  logic is_store, is_fetch, is_load;
  assign is_store = (acc_kind == 2'd1);
  assign is_fetch = (acc_kind == 2'd2);
  assign is_load  = !is_store && !is_fetch;

  logic pg_r, pg_w, pg_x;
  assign pg_r = !(!priv_user && sup_no_udata && pte_user);
  assign pg_w = pg_r && (pte_rw || (!priv_user && !md_wp));
  assign pg_x = !pte_nx && (priv_user || !(md_smep && pte_user));

  logic [RIGHTS_W-1:0] rights;
  always_comb begin
    rights = '0;
    if (pte_user && key_user_en) rights = user_rights;
    else if (!pte_user && key_sup_en) rights = sup_rights;
  end

  logic key_on, k_ad, k_wd, k_r, k_w;
  assign key_on = |rights;
  assign k_ad   = rights[{pte_key, 1'b0}];
  assign k_wd   = rights[{pte_key, 1'b1}];
  assign k_r    = !key_on || !k_ad;
  assign k_w    = !key_on || (!k_ad && !(k_wd && (priv_user || md_wp)));

  logic walk_np, walk_rsvd, usr_sup, key_deny, fin_deny;
  logic [2:0] fin;
  assign walk_np   = (walk_stat == 2'd1);
  assign walk_rsvd = walk_stat[1];
  assign usr_sup   = priv_user && !pte_user;
  assign fin       = {pg_r && k_r, pg_w && k_w, pg_x};
  assign key_deny  = (is_load && !k_r) || (is_store && !k_w);
  assign fin_deny  = (is_load && !fin[2]) || (is_store && !fin[1]) || (is_fetch && !fin[0]);

  logic n_fault;
  logic [5:0] base, n_err;
  always_comb begin
    base = '0;
    if (walk_np)        base = '0;
    else if (walk_rsvd) base[EB_RSVD] = 1'b1;
    else if (usr_sup)   base[EB_P] = 1'b1;
    else if (key_deny) begin
      base[EB_PK] = 1'b1;
      base[EB_P]  = 1'b1;
    end else if (fin_deny) base[EB_P] = 1'b1;
  end

  assign n_fault = walk_np || walk_rsvd || usr_sup || key_deny || fin_deny;

  always_comb begin
    n_err = '0;
    if (n_fault) begin
      n_err = base;
      n_err[EB_U]  = priv_user;
      n_err[EB_W]  = is_store;
      n_err[EB_ID] = is_fetch && (md_nxe || md_smep);
    end
  end

  logic blank;
  assign blank = walk_np || walk_rsvd || usr_sup;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      perm_r    <= 1'b0;
      perm_w    <= 1'b0;
      perm_x    <= 1'b0;
      fault     <= 1'b0;
      err_code  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        {perm_r, perm_w, perm_x} <= blank ? 3'b000 : fin;
        fault    <= n_fault;
        err_code <= n_err;
      end
    end
  end

  a_r9_no_key_fault_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && err_code[EB_PK]) |-> ($past(acc_kind) != 2'd2));

  a_r9_key_fault_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && err_code[EB_PK]) |-> (fault && err_code[EB_P]));

  a_r11_quiet_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |-> (err_code == 6'd0));

  a_r11_granted_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault) |->
      (($past(acc_kind) == 2'd1) ? perm_w : ($past(acc_kind) == 2'd2) ? perm_x : perm_r));

  a_r10_user_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && fault) |-> (err_code[EB_U] == $past(priv_user)));

  a_r2_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(walk_stat) == 2'd1) |->
      (fault && !err_code[EB_P] && !err_code[EB_RSVD] && !perm_r && !perm_w && !perm_x));

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rsp_valid == $past(req_valid)));
endmodule

// File: tb/pg_perm_check_test.sv
module pg_perm_check_test;
  localparam int CLK_P = 10;
  localparam int KW = 4;
  localparam int RW = 2 << KW;

  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
  logic [1:0] acc_kind, walk_stat;
  logic priv_user, sup_no_udata, pte_user, pte_rw, pte_nx;
  logic [KW-1:0] pte_key;
  logic md_wp, md_nxe, md_smep, key_user_en, key_sup_en;
  logic [RW-1:0] user_rights, sup_rights;
  logic rsp_valid, perm_r, perm_w, perm_x, fault;
  logic [5:0] err_code;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #(CLK_P/2) clk = ~clk;

  pg_perm_check #(.KEY_W(KW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .walk_stat(walk_stat), .priv_user(priv_user), .sup_no_udata(sup_no_udata),
    .pte_user(pte_user), .pte_rw(pte_rw), .pte_nx(pte_nx), .pte_key(pte_key),
    .md_wp(md_wp), .md_nxe(md_nxe), .md_smep(md_smep),
    .key_user_en(key_user_en), .key_sup_en(key_sup_en),
    .user_rights(user_rights), .sup_rights(sup_rights),
    .rsp_valid(rsp_valid), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .fault(fault), .err_code(err_code));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected < 20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic clear_ctx();
    acc_kind = 2'd0; walk_stat = 2'd0; priv_user = 0; sup_no_udata = 0;
    pte_user = 0; pte_rw = 0; pte_nx = 0; pte_key = '0;
    md_wp = 0; md_nxe = 0; md_smep = 0; key_user_en = 0; key_sup_en = 0;
    user_rights = '0; sup_rights = '0;
  endtask

  task automatic expect_out(string tag, logic [2:0] rwx, logic f, logic [5:0] e);
    n_chk++;
    if (!rsp_valid || {perm_r, perm_w, perm_x} != rwx || fault != f || err_code != e) begin
      n_bad++;
      $display("FAIL %s: got v=%b rwx=%b f=%b err=%0d expected v=1 rwx=%b f=%b err=%0d",
               tag, rsp_valid, {perm_r, perm_w, perm_x}, fault, err_code, rwx, f, e);
    end
  endtask

  task automatic fire(string tag, logic [2:0] rwx, logic f, logic [5:0] e);
    req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    expect_out(tag, rwx, f, e);
    clear_ctx();
  endtask

  task automatic t_reset();
    n_chk++;
    if (rsp_valid || perm_r || perm_w || perm_x || fault || err_code != 0) begin
      n_bad++;
      $display("FAIL R1 reset: got v=%b rwx=%b f=%b err=%0d expected all 0",
               rsp_valid, {perm_r, perm_w, perm_x}, fault, err_code);
    end
  endtask

  task automatic t_walk();
    priv_user = 1; pte_user = 1; acc_kind = 2'd1; walk_stat = 2'd1;
    fire("R2 not-present user store", 3'b000, 1, 6'd6);
    acc_kind = 2'd2; md_nxe = 1; walk_stat = 2'd2; pte_rw = 1;
    fire("R2 reserved fetch", 3'b000, 1, 6'd24);
  endtask

  task automatic t_user_sup();
    priv_user = 1; pte_rw = 1;
    fire("R3 user on supervisor page", 3'b000, 1, 6'd5);
  endtask

  task automatic t_read();
    sup_no_udata = 1; pte_user = 1; pte_rw = 1;
    fire("R4 no-udata sup load user page", 3'b001, 1, 6'd1);
    sup_no_udata = 1;
    fire("R4 no-udata sup page read ok", 3'b111, 0, 6'd0);
  endtask

  task automatic t_write();
    md_wp = 1; acc_kind = 2'd1;
    fire("R5 wp sup store ro page", 3'b101, 1, 6'd3);
    priv_user = 1; pte_user = 1; acc_kind = 2'd1;
    fire("R5 user store ro page", 3'b101, 1, 6'd7);
  endtask

  task automatic t_exec();
    md_smep = 1; pte_user = 1; acc_kind = 2'd2;
    fire("R6 smep sup fetch user page", 3'b110, 1, 6'd17);
    priv_user = 1; pte_user = 1; pte_nx = 1; md_nxe = 1; acc_kind = 2'd2;
    fire("R10 user fetch nx page with nxe", 3'b100, 1, 6'd21);
    pte_nx = 1; acc_kind = 2'd2;
    fire("R10 fetch fault without id bit", 3'b110, 1, 6'd1);
  endtask

  task automatic t_keys();
    priv_user = 1; pte_user = 1; pte_rw = 1; key_user_en = 1;
    user_rights[6] = 1'b1; pte_key = 4'd3;
    fire("R8 access-disable key3", 3'b001, 1, 6'd37);
    priv_user = 1; pte_user = 1; pte_rw = 1; key_sup_en = 1;
    sup_rights = '1; pte_key = 4'd3;
    fire("R7 user page ignores sup rights", 3'b111, 0, 6'd0);
    md_wp = 1; pte_rw = 1; key_sup_en = 1; sup_rights[11] = 1'b1;
    pte_key = 4'd5; acc_kind = 2'd1;
    fire("R8 wd with wp sup store", 3'b101, 1, 6'd35);
    pte_rw = 1; key_sup_en = 1; sup_rights[11] = 1'b1; pte_key = 4'd5; acc_kind = 2'd1;
    fire("R8 wd ignored sup no wp", 3'b111, 0, 6'd0);
    priv_user = 1; pte_user = 1; pte_rw = 1; key_user_en = 1;
    user_rights[6] = 1'b1; pte_key = 4'd4;
    fire("R8 other key no effect", 3'b111, 0, 6'd0);
    key_user_en = 1; user_rights = '1; pte_rw = 1; md_wp = 1; acc_kind = 2'd1;
    fire("R7 sup page ignores user rights", 3'b111, 0, 6'd0);
  endtask

  task automatic t_key_fault();
    priv_user = 1; pte_user = 1; key_user_en = 1; user_rights[4] = 1'b1;
    pte_key = 4'd2; acc_kind = 2'd2;
    fire("R9 fetch exempt from keys", 3'b001, 0, 6'd0);
    priv_user = 1; pte_user = 1; key_user_en = 1; user_rights[3] = 1'b1;
    pte_key = 4'd1; acc_kind = 2'd1;
    fire("R9 key fault before page fault", 3'b101, 1, 6'd39);
    priv_user = 1; pte_user = 1; key_user_en = 1; user_rights[31] = 1'b1;
    pte_key = 4'd15; pte_rw = 1;
    fire("R11 top key wd load ok", 3'b101, 0, 6'd0);
  endtask

  task automatic t_idle();
    @(posedge clk); @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 idle: got rsp_valid=%b expected 0", rsp_valid);
    end
  endtask

  initial begin
    clear_ctx();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_walk();
    t_user_sup();
    t_read();
    t_write();
    t_exec();
    t_keys();
    t_key_fault();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule